// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This unit watches 28 general-purpose input pins and records level transitions as sticky event flags. Each pin has two enable bits. One arms detection of low-to-high transitions and the other arms detection of high-to-low transitions. With both set, either transition records an event.

Software reads the event flags through a small register port and retires them by writing ones. Event flags of pins 0 to 10 each drive a dedicated interrupt request line. The flags of pins 11 to 27 merge into one shared summary request. A per-pin wake mask decides which recorded events may raise the wakeup output.

Every pin first passes through a two-flop synchroniser. It then feeds a per-pin level tracker, a two-state machine with states `LVL_LOW` and `LVL_HIGH`. The transition named *rise* moves the tracker from `LVL_LOW` to `LVL_HIGH` and emits a one-cycle rise event. The transition named *fall* moves it from `LVL_HIGH` to `LVL_LOW` and emits a one-cycle fall event. Otherwise the tracker holds its state and emits nothing.

The tracker resets to `LVL_LOW`. A pin change applied just before clock edge k sets its event flag at edge k+2.

Register map:

| Address | Register |
|---|---|
| 0 | rise enables |
| 1 | fall enables |
| 2 | event flags, write-one-to-clear |
| 3 | wake mask |

Bit n of each register belongs to pin n.

Top module: `gpio_eirq_unit`

## Requirements
- R1: After reset, all four registers read zero, and every request output and the wake output are low.
- R2: With its rise-enable bit (address 0, bit n) set, a low-to-high transition on pin n sets event flag n, readable at address 2, within four clock cycles.
- R3: With its fall-enable bit (address 1, bit n) set, a high-to-low transition on pin n sets event flag n.
- R4: With both enable bits of a pin set, a transition in either direction sets its event flag.
- R5: A transition whose direction is not enabled for that pin leaves the event flags unchanged.
- R6: Writing address 2 clears each flag whose written bit is 1 and leaves each flag whose written bit is 0.
- R7: An event flag stays set through further transitions and after the pin's enables are cleared, until a clearing write.
- R8: Request output bit n, for n from 0 to 10, equals event flag n.
- R9: The summary request is the OR of event flags 11 to 27; flags 0 to 10 do not drive it.
- R10: The wake output is high exactly when some event flag is set whose wake-mask bit (address 3) is also set.
- R11: When a clearing write and a new enabled event hit the same flag in the same cycle, the flag ends set.
- R12: Addresses 0, 1 and 3 read back the last value written. Writing ones to address 2 never sets a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 28 | Asynchronous pin levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 28 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 28 | Register read data (combinational) |
| irq_direct_o | output | 11 | Per-pin requests for pins 0 to 10 |
| irq_summary_o | output | 1 | Shared request for pins 11 to 27 |
| wake_o | output | 1 | Wakeup request |

## Verification
The sharpest case lands a clearing write in the exact cycle a new enabled event reaches the same flag. A design that lets the clear win would drop that event, and the flag would read zero. The bench also arms a pin for one direction only and drives the other, which catches swapped enable registers and trackers that fire on any change. Pin 12 is used to show that only high-numbered flags feed the summary line, and that the wake output follows the mask rather than any set flag. The bench clears one pin's enables after its flag is set, so a design that makes flags depend on current enables loses the flag.

// File: rtl/gpio_eirq_pkg.sv
package gpio_eirq_pkg;

    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_RISE_EN = 2'd0,
        REG_FALL_EN = 2'd1,
        REG_STATUS  = 2'd2,
        REG_WAKE_EN = 2'd3
    } reg_sel_t;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_t;

endpackage

// File: rtl/gpio_eirq_sync.sv
module gpio_eirq_sync #(
    parameter int WIDTH  = 28,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= '0;
            end
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_eirq_edge.sv
module gpio_eirq_edge
    import gpio_eirq_pkg::*;
#(
    parameter int WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    generate
        for (genvar p = 0; p < WIDTH; p++) begin : g_pin
            lvl_state_t st_q;
            lvl_state_t st_d;
            logic       rise_c;
            logic       fall_c;

            // state register
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= LVL_LOW;
                end else begin
                    st_q <= st_d;
                end
            end

            // next state: rise and fall transitions
            always_comb begin
                st_d = st_q;
                unique case (st_q)
                    LVL_LOW:  if (lvl_i[p])  st_d = LVL_HIGH;
                    LVL_HIGH: if (!lvl_i[p]) st_d = LVL_LOW;
                    default:  st_d = LVL_LOW;
                endcase
            end

            // outputs
            always_comb begin
                rise_c = 1'b0;
                fall_c = 1'b0;
                unique case (st_q)
                    LVL_LOW:  rise_c = lvl_i[p];
                    LVL_HIGH: fall_c = !lvl_i[p];
                    default: begin
                        rise_c = 1'b0;
                        fall_c = 1'b0;
                    end
                endcase
            end

            assign rise_o[p] = rise_c;
            assign fall_o[p] = fall_c;
        end
    endgenerate

    // R2: a rise event needs the level to have been low one cycle earlier
    p_rise_from_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |-> ((rise_o & $past(lvl_i)) == '0));

    // R3: a fall event needs the level to have been high one cycle earlier
    p_fall_from_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_o != '0) |-> ((fall_o & ~$past(lvl_i)) == '0));

endmodule

// File: rtl/gpio_eirq_regs.sv
module gpio_eirq_regs
    import gpio_eirq_pkg::*;
#(
    parameter int WIDTH = 28
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [REG_ADDR_W-1:0] wr_addr_i,
    input  logic [WIDTH-1:0]      wr_data_i,
    input  logic [REG_ADDR_W-1:0] rd_addr_i,
    input  logic [WIDTH-1:0]      rise_ev_i,
    input  logic [WIDTH-1:0]      fall_ev_i,
    output logic [WIDTH-1:0]      rd_data_o,
    output logic [WIDTH-1:0]      status_o,
    output logic [WIDTH-1:0]      wake_en_o
);

    logic [WIDTH-1:0] rise_en_q;
    logic [WIDTH-1:0] fall_en_q;
    logic [WIDTH-1:0] wake_en_q;
    logic [WIDTH-1:0] status_q;
    logic [WIDTH-1:0] status_d;
    logic [WIDTH-1:0] hits;
    logic [WIDTH-1:0] clr_mask;
    logic             wr_status;
    reg_sel_t         wr_sel;
    reg_sel_t         rd_sel;

    assign wr_sel    = reg_sel_t'(wr_addr_i);
    assign rd_sel    = reg_sel_t'(rd_addr_i);
    assign wr_status = wr_en_i && (wr_sel == REG_STATUS);

    assign hits     = (rise_ev_i & rise_en_q) | (fall_ev_i & fall_en_q);
    assign clr_mask = wr_status ? wr_data_i : '0;
    // a new event outranks a clear in the same cycle
    assign status_d = (status_q & ~clr_mask) | hits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_en_q <= '0;
            fall_en_q <= '0;
            wake_en_q <= '0;
        end else if (wr_en_i) begin
            unique case (wr_sel)
                REG_RISE_EN: rise_en_q <= wr_data_i;
                REG_FALL_EN: fall_en_q <= wr_data_i;
                REG_WAKE_EN: wake_en_q <= wr_data_i;
                REG_STATUS:  ;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        unique case (rd_sel)
            REG_RISE_EN: rd_data_o = rise_en_q;
            REG_FALL_EN: rd_data_o = fall_en_q;
            REG_STATUS:  rd_data_o = status_q;
            REG_WAKE_EN: rd_data_o = wake_en_q;
            default:     rd_data_o = '0;
        endcase
    end

    assign status_o  = status_q;
    assign wake_en_o = wake_en_q;

    // R7: without a clearing write no flag drops
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_status |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R5: a flag only appears where an enabled event was seen
    p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & ~$past(status_q) & ~$past(hits)) == '0);

    // R11: an event coinciding with a clear still leaves the flag set
    p_edge_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_status |=> (($past(hits) & ~status_q) == '0));

endmodule

// File: rtl/gpio_eirq_unit.sv
module gpio_eirq_unit
    import gpio_eirq_pkg::*;
#(
    parameter int NUM_PINS    = 28,
    parameter int NUM_DIRECT  = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_i,
    input  logic                  wr_en_i,
    input  logic [REG_ADDR_W-1:0] wr_addr_i,
    input  logic [NUM_PINS-1:0]   wr_data_i,
    input  logic [REG_ADDR_W-1:0] rd_addr_i,
    output logic [NUM_PINS-1:0]   rd_data_o,
    output logic [NUM_DIRECT-1:0] irq_direct_o,
    output logic                  irq_summary_o,
    output logic                  wake_o
);

    localparam int NUM_SHARED = NUM_PINS - NUM_DIRECT;

    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] rise_ev;
    logic [NUM_PINS-1:0] fall_ev;
    logic [NUM_PINS-1:0] status;
    logic [NUM_PINS-1:0] wake_en;
    logic [NUM_PINS-1:0] any_ev;

    gpio_eirq_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_sync)
    );

    gpio_eirq_edge #(
        .WIDTH (NUM_PINS)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (pin_sync),
        .rise_o (rise_ev),
        .fall_o (fall_ev)
    );

    gpio_eirq_regs #(
        .WIDTH (NUM_PINS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .rise_ev_i (rise_ev),
        .fall_ev_i (fall_ev),
        .rd_data_o (rd_data_o),
        .status_o  (status),
        .wake_en_o (wake_en)
    );

    generate
        for (genvar d = 0; d < NUM_DIRECT; d++) begin : g_direct
            assign irq_direct_o[d] = status[d];
        end
    endgenerate

    assign irq_summary_o = |status[NUM_PINS-1:NUM_DIRECT];
    assign wake_o        = |(status & wake_en);
    assign any_ev        = rise_ev | fall_ev;

    // R8: a direct request only rises after an event on that same pin
    p_direct_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_direct_o & ~$past(irq_direct_o) & ~$past(any_ev[NUM_DIRECT-1:0])) == '0));

    // R9: the summary request only rises after an event on a shared pin
    p_summary_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_summary_o) |-> ($past(any_ev[NUM_PINS-1:NUM_DIRECT]) != '0));

    initial begin
        assert (NUM_SHARED > 0);
    end

endmodule

// File: tb/gpio_eirq_unit_tb.sv
`timescale 1ns/1ps
module gpio_eirq_unit_tb;

    typedef struct {
        string       tag;
        logic [1:0]  addr;
        logic [27:0] data;
        logic [12:0] outs;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] pins = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [27:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [27:0] rd_data;
    logic [10:0] irq_direct;
    logic        irq_summary;
    logic        wake;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    item_t sb_q[$];

    always #2 clk = ~clk;

    gpio_eirq_unit u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_i         (pins),
        .wr_en_i       (wr_en),
        .wr_addr_i     (wr_addr),
        .wr_data_i     (wr_data),
        .rd_addr_i     (rd_addr),
        .rd_data_o     (rd_data),
        .irq_direct_o  (irq_direct),
        .irq_summary_o (irq_summary),
        .wake_o        (wake)
    );

    // monitor: pop expected items and compare
    initial begin
        forever begin
            wait (sb_q.size() > 0);
            @(negedge clk);
            begin
                item_t it;
                logic [12:0] got;
                it = sb_q[0];
                rd_addr = it.addr;
                #1;
                got = {wake, irq_summary, irq_direct};
                checks++;
                if (rd_data !== it.data || got !== it.outs) begin
                    errors++;
                    $display("FAIL %s addr=%0d data=%h exp=%h outs=%h exp=%h",
                             it.tag, it.addr, rd_data, it.data, got, it.outs);
                end
                void'(sb_q.pop_front());
            end
        end
    end

    task automatic expect_item(input string tag, input logic [1:0] addr,
                               input logic [27:0] data, input logic [12:0] outs);
        item_t it;
        it.tag = tag; it.addr = addr; it.data = data; it.outs = outs;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
        #2;
    endtask

    task automatic reg_write(input logic [1:0] addr, input logic [27:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pin_set(input int idx, input logic val);
        @(negedge clk);
        pins[idx] = val;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        expect_item("R1 rise reset", 2'd0, 28'h0, 13'h0);
        expect_item("R1 fall reset", 2'd1, 28'h0, 13'h0);
        expect_item("R1 status reset", 2'd2, 28'h0, 13'h0);
        expect_item("R1 wake reset", 2'd3, 28'h0, 13'h0);

        reg_write(2'd0, 28'h0001001);
        reg_write(2'd1, 28'h0001002);
        reg_write(2'd3, 28'h0001000);
        reg_write(2'd2, 28'hFFFFFFF);
        expect_item("R12 rise readback", 2'd0, 28'h0001001, 13'h0);
        expect_item("R12 fall readback", 2'd1, 28'h0001002, 13'h0);
        expect_item("R12 wake readback", 2'd3, 28'h0001000, 13'h0);
        expect_item("R12 ones to status", 2'd2, 28'h0, 13'h0);

        pin_set(0, 1'b1);
        expect_item("R2 R8 pin0 rise", 2'd2, 28'h0000001, 13'h001);
        pin_set(1, 1'b1);
        expect_item("R5 pin1 rise not armed", 2'd2, 28'h0000001, 13'h001);
        pin_set(1, 1'b0);
        expect_item("R3 pin1 fall", 2'd2, 28'h0000003, 13'h003);
        pin_set(5, 1'b1);
        pin_set(5, 1'b0);
        expect_item("R5 pin5 unarmed", 2'd2, 28'h0000003, 13'h003);

        pin_set(12, 1'b1);
        expect_item("R4 R9 R10 pin12 rise", 2'd2, 28'h0001003, 13'h1803);
        reg_write(2'd2, 28'h0001000);
        expect_item("R6 R10 clear pin12", 2'd2, 28'h0000003, 13'h003);
        pin_set(12, 1'b0);
        expect_item("R4 pin12 fall", 2'd2, 28'h0001003, 13'h1803);
        reg_write(2'd2, 28'h0);
        expect_item("R6 write zero", 2'd2, 28'h0001003, 13'h1803);
        reg_write(2'd2, 28'h0001002);
        expect_item("R6 R9 partial clear", 2'd2, 28'h0000001, 13'h001);

        pin_set(0, 1'b0);
        pin_set(0, 1'b1);
        expect_item("R7 repeat edge", 2'd2, 28'h0000001, 13'h001);
        reg_write(2'd0, 28'h0);
        pin_set(0, 1'b0);
        pin_set(0, 1'b1);
        expect_item("R7 enables cleared", 2'd2, 28'h0000001, 13'h001);

        // R11: clearing write lands in the cycle the pin0 event is seen
        reg_write(2'd0, 28'h0000001);
        pin_set(0, 1'b0);
        @(negedge clk);
        pins[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 28'h0000001;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        expect_item("R11 event beats clear", 2'd2, 28'h0000001, 13'h001);
        reg_write(2'd2, 28'h0000001);
        expect_item("R6 plain clear", 2'd2, 28'h0, 13'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule